// File: doc/BRIEF.md
# UART Baud Divisor Search Engine

This block works out how a UART should divide its functional clock to reach a requested baud rate. It takes the clock frequency and the target rate as 32-bit unsigned integers. It then walks every permitted oversampling ratio. For each ratio it tests two integer divisors: the truncated quotient and that quotient plus one. It keeps the ratio and divisor whose achieved rate lies closest to the target.

The search uses one shared restoring divider. The divider makes one quotient bit per clock, and each ratio needs three divisions. A single start pulse launches the search while `busy_o` is high. `done_o` then pulses once, and the result holds until the next accepted start. The result has five parts: the ratio, the divisor, the residual rate error, a flag that marks a match as too poor, and a flag that requests sampling on both clock edges when the ratio is small.

All differences are formed in 32-bit unsigned arithmetic with wraparound. Products are truncated to 32 bits in the same way. This makes the result exactly reproducible by a software model.

Top module: `baud_search`

## Requirements
- R1: Oversampling ratios are evaluated in ascending order from 4 to 32. A ratio replaces the running best when its error is less than or equal to the best error, so on a tie the larger ratio wins. For example, clock 0 with target 1 gives ratio 32, divisor 2 and residual 1.
- R2: For ratio r, the base divisor q is the truncated quotient of the clock by the 32-bit-wrapped product target×r, and a q of zero becomes 1. Any division by a zero divisor yields an all-ones quotient.
- R3: Two errors are formed modulo 2^32. The low error is clock/(r×q) − target. The high error is target − clock/(r×(q+1)). When the high error is strictly smaller, divisor q+1 with the high error is taken; otherwise q with the low error.
- R4: The running best starts with error equal to the target, ratio 0 and divisor 0. After `done_o`, `ratio_o`, `divisor_o` and `resid_o` present the final best.
- R5: `fail_o` is 1 exactly when the final residual exceeds (target/100)×3, where the division truncates before the multiply.
- R6: `both_edge_o` is 1 exactly when the final ratio lies in 4..7.
- R7: After an accepted start with a nonzero target, `done_o` rises on the 2989th rising edge, counting the accepting edge as the first. `busy_o` is high in every cycle before that and falls with `done_o`. `done_o` lasts exactly one cycle.
- R8: A start with target 0 runs no search. On the accepting edge it gives `done_o`=1, `fail_o`=1 and ratio, divisor, residual and `both_edge_o` all 0, and `busy_o` stays 0.
- R9: Clock and target are captured at the accepting edge. Input changes and start pulses during a search do not change its result or its timing.
- R10: All result outputs stay constant in every cycle in which `done_o` is low.
- R11: After reset, `busy_o`, `done_o` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch request, honoured only when idle |
| clk_hz_i | input | 32 | Functional clock frequency in Hz |
| baud_i | input | 32 | Target baud rate |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ratio_o | output | 6 | Chosen oversampling ratio |
| divisor_o | output | 32 | Chosen integer divisor |
| resid_o | output | 32 | Residual error of the chosen pair |
| fail_o | output | 1 | Residual above the 3 % tolerance, or target was zero |
| both_edge_o | output | 1 | Both-edge sampling request for small ratios |

## Verification
Each ratio costs 103 cycles: three divisions of 34 cycles each (a launch cycle, 32 quotient steps and a hand-off cycle), plus one selection cycle. Adding the launch edge and the final publishing edge places `done_o` on the 2989th edge after an accepted start. A zero-target rejection appears on the accepting edge itself. The bench counts rising edges from the one that accepts start and samples every output on the falling edge that follows. It checks the edge count against these figures, checks that `busy_o` is high at every falling edge before completion, and checks that `done_o` is low one falling edge later. The residual, divisor and flags are compared only at the completion sample and again after ten idle cycles.

// File: rtl/baud_search_pkg.sv
package baud_search_pkg;

    localparam int WORD_W       = 32;
    localparam int RATIO_LO     = 4;
    localparam int RATIO_HI     = 32;
    localparam int RATIO_W      = $clog2(RATIO_HI + 1);
    localparam int DUAL_EDGE_HI = 7;
    localparam int TOL_PCT      = 3;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [RATIO_W-1:0] ratio_t;

    // Search sequencer phases: launch/wait pairs for the three divisions.
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_BASE_GO,
        PH_BASE_WAIT,
        PH_LO_GO,
        PH_LO_WAIT,
        PH_HI_GO,
        PH_HI_WAIT,
        PH_PICK,
        PH_PUBLISH
    } phase_e;

    // One ratio/divisor pairing together with its rate error.
    typedef struct packed {
        ratio_t ratio;
        word_t  divisor;
        word_t  resid;
    } pick_t;

    function automatic word_t tol_limit(input word_t target);
        return (target / word_t'(100)) * word_t'(TOL_PCT);
    endfunction

    function automatic logic in_band(input ratio_t r, input ratio_t lo, input ratio_t hi);
        return (r >= lo) && (r <= hi);
    endfunction

    function automatic word_t clamp_one(input word_t q);
        return (q == '0) ? word_t'(1) : q;
    endfunction

endpackage

// File: rtl/baud_div.sv
// Restoring unsigned divider, one quotient bit per cycle.
module baud_div #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         go_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] quo_o,
    output logic         valid_o,
    output logic         busy_o
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  qsh_q;
    logic [W-1:0]  den_q;
    logic [CW-1:0] step_q;
    logic [W+1:0]  trial;
    logic          fits;
    logic [W-1:0]  rem_nxt;

    always_comb begin
        trial   = {1'b0, rem_q, qsh_q[W-1]} - {2'b00, den_q};
        fits    = ~trial[W+1];
        rem_nxt = fits ? trial[W-1:0] : {rem_q[W-2:0], qsh_q[W-1]};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rem_q   <= '0;
            qsh_q   <= '0;
            den_q   <= '0;
            step_q  <= '0;
            busy_o  <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (go_i && !busy_o) begin
                rem_q  <= '0;
                qsh_q  <= num_i;
                den_q  <= den_i;
                step_q <= '0;
                busy_o <= 1'b1;
            end else if (busy_o) begin
                rem_q  <= rem_nxt;
                qsh_q  <= {qsh_q[W-2:0], fits};
                step_q <= step_q + 1'b1;
                if (step_q == CW'(W - 1)) begin
                    busy_o  <= 1'b0;
                    valid_o <= 1'b1;
                end
            end
        end
    end

    assign quo_o = qsh_q;

    // R7: each quotient is announced for a single cycle
    p_div_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> !valid_o);
    // R7: a quotient is never announced while steps remain
    p_div_valid_idle_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> !busy_o);
    // R7: the sequencer launches only into an idle divider
    p_div_go_idle_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        go_i |-> !busy_o);

endmodule

// File: rtl/baud_cand.sv
// Chooses between the base divisor and its successor for one ratio.
module baud_cand
    import baud_search_pkg::*;
(
    input  word_t  target_i,
    input  ratio_t ratio_i,
    input  word_t  base_q_i,
    input  word_t  rate_lo_i,
    input  word_t  rate_hi_i,
    output pick_t  cand_o
);
    word_t err_lo;
    word_t err_hi;
    logic  take_hi;

    always_comb begin
        err_lo  = rate_lo_i - target_i;
        err_hi  = target_i - rate_hi_i;
        take_hi = err_hi < err_lo;
        cand_o.ratio   = ratio_i;
        cand_o.divisor = take_hi ? base_q_i + word_t'(1) : base_q_i;
        cand_o.resid   = take_hi ? err_hi : err_lo;
    end

endmodule

// File: rtl/baud_best.sv
// Running best pairing; later ratios win ties.
module baud_best
    import baud_search_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  init_i,
    input  word_t init_err_i,
    input  logic  upd_i,
    input  pick_t cand_i,
    output pick_t best_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            best_o <= '0;
        end else if (init_i) begin
            best_o.ratio   <= '0;
            best_o.divisor <= '0;
            best_o.resid   <= init_err_i;
        end else if (upd_i && (cand_i.resid <= best_o.resid)) begin
            best_o <= cand_i;
        end
    end

    // R4: an update never worsens the kept error
    p_best_monotone_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (upd_i && !init_i) |=> (best_o.resid <= $past(best_o.resid)));

endmodule

// File: rtl/baud_search.sv
module baud_search
    import baud_search_pkg::*;
#(
    parameter int RATIO_MIN = RATIO_LO,
    parameter int RATIO_MAX = RATIO_HI,
    parameter int DUAL_MAX  = DUAL_EDGE_HI
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                start_i,
    input  logic [WORD_W-1:0]   clk_hz_i,
    input  logic [WORD_W-1:0]   baud_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [RATIO_W-1:0]  ratio_o,
    output logic [WORD_W-1:0]   divisor_o,
    output logic [WORD_W-1:0]   resid_o,
    output logic                fail_o,
    output logic                both_edge_o
);
    localparam ratio_t R_FIRST = ratio_t'(RATIO_MIN);
    localparam ratio_t R_LAST  = ratio_t'(RATIO_MAX);
    localparam ratio_t R_DUAL  = ratio_t'(DUAL_MAX);

    phase_e ph_q;
    word_t  clk_q;
    word_t  tgt_q;
    ratio_t ratio_q;
    word_t  base_q;
    word_t  rate_lo_q;
    word_t  rate_hi_q;

    word_t  ratio_w;
    word_t  div_den;
    logic   div_go;
    word_t  div_quo;
    logic   div_valid;
    logic   div_busy;

    logic   accept;
    logic   best_init;
    logic   best_upd;
    pick_t  cand;
    pick_t  best;

    assign ratio_w   = word_t'(ratio_q);
    assign accept    = (ph_q == PH_IDLE) && start_i;
    assign best_init = accept && (baud_i != '0);
    assign best_upd  = (ph_q == PH_PICK);

    // Divisor operand for the division launched in each phase.
    always_comb begin
        div_go  = 1'b0;
        div_den = '0;
        unique case (ph_q)
            PH_BASE_GO: begin div_go = 1'b1; div_den = tgt_q * ratio_w; end
            PH_LO_GO:   begin div_go = 1'b1; div_den = ratio_w * base_q; end
            PH_HI_GO:   begin div_go = 1'b1; div_den = ratio_w * (base_q + word_t'(1)); end
            default:    begin div_go = 1'b0; div_den = '0; end
        endcase
    end

    baud_div #(.W(WORD_W)) u_div (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .go_i    (div_go),
        .num_i   (clk_q),
        .den_i   (div_den),
        .quo_o   (div_quo),
        .valid_o (div_valid),
        .busy_o  (div_busy)
    );

    baud_cand u_cand (
        .target_i  (tgt_q),
        .ratio_i   (ratio_q),
        .base_q_i  (base_q),
        .rate_lo_i (rate_lo_q),
        .rate_hi_i (rate_hi_q),
        .cand_o    (cand)
    );

    baud_best u_best (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .init_i     (best_init),
        .init_err_i (baud_i),
        .upd_i      (best_upd),
        .cand_i     (cand),
        .best_o     (best)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ph_q        <= PH_IDLE;
            clk_q       <= '0;
            tgt_q       <= '0;
            ratio_q     <= '0;
            base_q      <= '0;
            rate_lo_q   <= '0;
            rate_hi_q   <= '0;
            busy_o      <= 1'b0;
            done_o      <= 1'b0;
            ratio_o     <= '0;
            divisor_o   <= '0;
            resid_o     <= '0;
            fail_o      <= 1'b0;
            both_edge_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (ph_q)
                PH_IDLE: begin
                    if (start_i) begin
                        if (baud_i == '0) begin
                            ratio_o     <= '0;
                            divisor_o   <= '0;
                            resid_o     <= '0;
                            fail_o      <= 1'b1;
                            both_edge_o <= 1'b0;
                            done_o      <= 1'b1;
                        end else begin
                            clk_q   <= clk_hz_i;
                            tgt_q   <= baud_i;
                            ratio_q <= R_FIRST;
                            busy_o  <= 1'b1;
                            ph_q    <= PH_BASE_GO;
                        end
                    end
                end
                PH_BASE_GO: ph_q <= PH_BASE_WAIT;
                PH_BASE_WAIT: begin
                    if (div_valid) begin
                        base_q <= clamp_one(div_quo);
                        ph_q   <= PH_LO_GO;
                    end
                end
                PH_LO_GO: ph_q <= PH_LO_WAIT;
                PH_LO_WAIT: begin
                    if (div_valid) begin
                        rate_lo_q <= div_quo;
                        ph_q      <= PH_HI_GO;
                    end
                end
                PH_HI_GO: ph_q <= PH_HI_WAIT;
                PH_HI_WAIT: begin
                    if (div_valid) begin
                        rate_hi_q <= div_quo;
                        ph_q      <= PH_PICK;
                    end
                end
                PH_PICK: begin
                    if (ratio_q == R_LAST) begin
                        ph_q <= PH_PUBLISH;
                    end else begin
                        ratio_q <= ratio_q + 1'b1;
                        ph_q    <= PH_BASE_GO;
                    end
                end
                PH_PUBLISH: begin
                    ratio_o     <= best.ratio;
                    divisor_o   <= best.divisor;
                    resid_o     <= best.resid;
                    fail_o      <= best.resid > tol_limit(tgt_q);
                    both_edge_o <= in_band(best.ratio, R_FIRST, R_DUAL);
                    done_o      <= 1'b1;
                    busy_o      <= 1'b0;
                    ph_q        <= PH_IDLE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // R1: the walked ratio stays inside the permitted span
    p_ratio_span_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (ph_q != PH_IDLE && ph_q != PH_PUBLISH) |-> (ratio_q >= R_FIRST && ratio_q <= R_LAST));
    // R1: consecutive selections move to the next larger ratio
    p_ratio_step_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (ph_q == PH_PICK && ratio_q != R_LAST) |=> (ratio_q == $past(ratio_q) + 1'b1));
    // R6: both-edge request agrees with the published ratio
    p_both_edge_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (both_edge_o == (ratio_o >= R_FIRST && ratio_o <= R_DUAL)));
    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);
    // R7: busy only ends together with completion
    p_busy_fall_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_o) |-> done_o);
    // R8: a zero target is rejected on the accepting edge
    p_zero_reject_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (accept && baud_i == '0) |=> (done_o && fail_o && !busy_o));
    // R9: a running search is not disturbed by a new start
    p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && ph_q != PH_PUBLISH) |=> busy_o);
    // R10: results move only when completion is signalled
    p_result_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        !done_o |-> ($stable(ratio_o) && $stable(divisor_o) && $stable(resid_o)
                     && $stable(fail_o) && $stable(both_edge_o)));

endmodule

// File: tb/baud_search_bench.sv
module baud_search_bench;

    localparam int CLK_PERIOD   = 10;
    localparam int SEARCH_EDGES = 2989;
    localparam int EDGE_LIMIT   = 4000;
    localparam int WATCHDOG     = 190000;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] clk_hz;
    logic [31:0] baud;
    logic        busy;
    logic        done;
    logic [5:0]  ratio;
    logic [31:0] divisor;
    logic [31:0] resid;
    logic        fail;
    logic        both_edge;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    baud_search u_baud_search (
        .clk_i       (clk),
        .rst_i       (rst),
        .start_i     (start),
        .clk_hz_i    (clk_hz),
        .baud_i      (baud),
        .busy_o      (busy),
        .done_o      (done),
        .ratio_o     (ratio),
        .divisor_o   (divisor),
        .resid_o     (resid),
        .fail_o      (fail),
        .both_edge_o (both_edge)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] qdiv(input logic [31:0] a, input logic [31:0] b);
        return (b == 32'd0) ? 32'hFFFF_FFFF : a / b;
    endfunction

    // Reference search written from the requirements.
    task automatic model(input logic [31:0] f, input logic [31:0] b,
                         output logic [5:0] r_o, output logic [31:0] d_o,
                         output logic [31:0] e_o, output logic fl_o, output logic be_o);
        logic [31:0] best;
        logic [31:0] q;
        logic [31:0] e_lo;
        logic [31:0] e_hi;
        logic [31:0] t;
        r_o = '0; d_o = '0; e_o = '0; fl_o = 1'b1; be_o = 1'b0;
        if (b != 32'd0) begin
            best = b;
            for (int k = 4; k <= 32; k++) begin
                t    = 32'(k);
                q    = qdiv(f, b * t);
                if (q == 32'd0) q = 32'd1;
                e_lo = qdiv(f, t * q) - b;
                e_hi = b - qdiv(f, t * (q + 32'd1));
                if (e_lo > e_hi) begin
                    e_lo = e_hi;
                    q    = q + 32'd1;
                end
                if (e_lo <= best) begin
                    best = e_lo;
                    r_o  = 6'(k);
                    d_o  = q;
                end
            end
            e_o  = best;
            fl_o = best > ((b / 32'd100) * 32'd3);
            be_o = (r_o >= 6'd4) && (r_o <= 6'd7);
        end
    endtask

    task automatic run(input logic [31:0] f, input logic [31:0] b, input bit disturb, input bit hold);
        logic [5:0]  er;
        logic [31:0] ed;
        logic [31:0] ee;
        logic        ef;
        logic        eb;
        int          n;
        int          exp_n;
        bit          busy_ok;
        model(f, b, er, ed, ee, ef, eb);
        @(negedge clk);
        clk_hz = f;
        baud   = b;
        start  = 1'b1;
        n       = 0;
        busy_ok = 1'b1;
        while (1) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 1) start = 1'b0;
            if (disturb && n == 50) begin clk_hz = ~f; baud = b + 32'd7; end
            if (disturb && n == 100) start = 1'b1;
            if (disturb && n == 101) start = 1'b0;
            if (done) break;
            if (!busy) busy_ok = 1'b0;
            if (n >= EDGE_LIMIT) break;
        end
        exp_n = (b == 32'd0) ? 1 : SEARCH_EDGES;
        chk(n == exp_n, disturb ? "R9 latency under disturbance" : (b == 32'd0 ? "R8 latency" : "R7 latency"),
            32'(n), 32'(exp_n));
        if (b == 32'd0) chk(!busy && busy_ok, "R8 busy stays low", {31'd0, busy}, 32'd0);
        else            chk(busy_ok && !busy, "R7 busy window", {31'd0, busy_ok}, 32'd1);
        chk(ratio == er,       disturb ? "R9 ratio" : "R1 ratio",      {26'd0, ratio}, {26'd0, er});
        chk(divisor == ed,     disturb ? "R9 divisor" : "R2 divisor",  divisor, ed);
        chk(resid == ee,       "R3 residual",   resid, ee);
        chk(fail == ef,        "R5 fail flag",  {31'd0, fail}, {31'd0, ef});
        chk(both_edge == eb,   "R6 both edge",  {31'd0, both_edge}, {31'd0, eb});
        @(negedge clk);
        chk(!done, "R7 done single pulse", {31'd0, done}, 32'd0);
        if (hold) begin
            clk_hz = f ^ 32'h5A5A_5A5A;
            baud   = b + 32'd1000;
            repeat (10) @(negedge clk);
            chk(ratio == er && divisor == ed && resid == ee && fail == ef && both_edge == eb && !done,
                "R10 outputs held", divisor, ed);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] f;
        logic [31:0] b;
        void'($urandom(32'd2024));
        rst    = 1'b1;
        start  = 1'b0;
        clk_hz = '0;
        baud   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: idle outputs after reset
        chk(!busy && !done, "R11 reset handshake", {30'd0, busy, done}, 32'd0);
        chk(ratio == '0 && divisor == '0 && resid == '0, "R11 reset result", divisor | resid, 32'd0);
        chk(!fail && !both_edge, "R11 reset flags", {30'd0, fail, both_edge}, 32'd0);

        // R1: all ratios tie, the largest one is kept
        run(32'd0, 32'd1, 1'b0, 1'b1);
        chk(ratio == 6'd32 && divisor == 32'd2 && resid == 32'd1, "R1 tie keeps ratio 32",
            {26'd0, ratio}, 32'd32);
        // R6: exact match at ratio 5 asks for both edges
        run(32'd5000, 32'd1000, 1'b0, 1'b0);
        chk(ratio == 6'd5 && divisor == 32'd1 && resid == 32'd0 && both_edge, "R6 ratio 5 both edges",
            {26'd0, ratio}, 32'd5);
        // R8: zero target rejected
        run(32'd48_000_000, 32'd0, 1'b0, 1'b1);
        // R2: zero product forces an all-ones quotient in the reference as well
        run(32'hFFFF_FFFF, 32'h0800_0000, 1'b0, 1'b0);
        // R5: clock far below the target
        run(32'd1000, 32'd1_000_000, 1'b0, 1'b0);
        chk(fail == 1'b1, "R5 hopeless target flagged", {31'd0, fail}, 32'd1);
        // R4: typical console settings
        run(32'd48_000_000, 32'd115_200, 1'b0, 1'b0);
        run(32'd8_000_000, 32'd9_600, 1'b0, 1'b0);
        // R9: inputs and start toggled mid-search
        run(32'd48_000_000, 32'd115_200, 1'b1, 1'b0);

        for (int i = 0; i < 24; i++) begin
            f = $urandom;
            if (i % 4 == 0) f = f % 32'd10_000_000;
            if (i % 3 == 0) b = 32'd1 + ($urandom % 32'd2000);
            else            b = 32'd1 + ($urandom % 32'h0040_0000);
            run(f, b, 1'b0, (i % 8 == 0));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule